// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Sequencer

This block generates the time-multiplexed drive codes for a passive LCD panel run at 1/4 bias with 8, 9 or 10 common lines. Every output carries a 3-bit bias-level index, from 0 (lowest rail) to 4 (top rail). An analog ladder and output buffers outside this block turn each index into a voltage.

A step enable, pulsed once per oscillator period, advances the scan by one common slot. Once all active commons have had their slot, the frame polarity flips. For each segment, the block reads the dot bit for the currently selected common from a flat display-data vector and drives the level that sets that dot on or off. Two output pins change role with the duty: each acts as a segment at low duty and as an extra common at high duty.

Three controls override the normal drive: a segment blanking bit, a power-save mode that freezes the scan, and an active-low inhibit that clears the segment side during power-up.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: After reset the scan selects common 1 in an even frame at 1/8 duty. With no step, common 1 drives level 4, the other commons drive level 1, and segments drive according to the display data.
- R2: `duty_sel` code 0 selects 8 commons, code 1 selects 9, and codes 2 and 3 select 10. A new code is adopted only when the slot of the last active common ends, so the new scan starts at common 1.
- R3: Each cycle with `step_en` high and power-save low moves the scan to the next common. The step after the last active common returns the scan to common 1 and toggles the frame polarity.
- R4: The selected common drives level 4 in even frames and level 0 in odd frames. An unselected common drives level 1 in even frames and level 3 in odd frames.
- R5: A segment whose dot is 1 drives level 0 in even frames and level 4 in odd frames. A segment whose dot is 0 drives level 2.
- R6: The dot for segment s (1-based) and common c (1-based) at N commons is bit (s-1)·N + (c-1) of `disp_data`, where bit 0 is the first dot. Segments 1..73 are `seg_lvl` slices 3·(s-1) upward, segment 74 is `dual_b_lvl` and segment 75 is `dual_a_lvl`.
- R7: At 8 commons both shared pins are segments. At 9 commons `dual_a_lvl` is common 9 and `dual_b_lvl` is segment 74. At 10 commons `dual_a_lvl` is common 9 and `dual_b_lvl` is common 10.
- R8: With `seg_off` high, every segment output, including shared pins acting as segments, drives level 2 while the commons keep scanning.
- R9: With `power_save` high, every output drives level 0 and the scan holds its position. When power-save drops, the scan resumes from where it stopped.
- R10: With `blank_n` low, all segment outputs and both shared pins drive level 0. Commons keep scanning normally. Power-save takes precedence over `blank_n`, which takes precedence over `seg_off`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | One pulse per waveform time step |
| duty_sel | input | 2 | Requested number of commons |
| seg_off | input | 1 | Force all segments to the off level |
| power_save | input | 1 | Freeze the scan and pull all outputs to level 0 |
| blank_n | input | 1 | Active-low inhibit of the segment side |
| disp_data | input | 730 | Dot bits, segment-major with commons interleaved |
| com_lvl | output | 24 | Levels of commons 1..8, 3 bits each |
| seg_lvl | output | 219 | Levels of segments 1..73, 3 bits each |
| dual_a_lvl | output | 3 | Shared pin: segment 75 or common 9 |
| dual_b_lvl | output | 3 | Shared pin: segment 74 or common 10 |

## Verification
The scan position, frame polarity and active duty are the only registers. A step or duty change therefore shows on the outputs one clock edge after the cycle that presents it, and only when that cycle ends a frame for the duty case. The controls and the display data reach the outputs in the same cycle through combinational logic. The bench drives new inputs just after a falling edge, compares all outputs with its model one time unit later, and then advances its model at the following rising edge using the same inputs.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef logic [2:0] lvl_t;

  localparam lvl_t LVL_BOT = 3'd0;
  localparam lvl_t LVL_LO  = 3'd1;
  localparam lvl_t LVL_MID = 3'd2;
  localparam lvl_t LVL_HI  = 3'd3;
  localparam lvl_t LVL_TOP = 3'd4;

  // Value equals the number of commons added on top of the base count.
  typedef enum logic [1:0] {
    DUTY_BASE  = 2'd0,
    DUTY_PLUS1 = 2'd1,
    DUTY_PLUS2 = 2'd2
  } duty_e;

  function automatic duty_e decode_duty(input logic [1:0] code);
    if (code[1])      return DUTY_PLUS2;
    else if (code[0]) return DUTY_PLUS1;
    else              return DUTY_BASE;
  endfunction
endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_seq_pkg::*;
#(
  parameter int COM_BASE = 8,
  localparam int NC_MAX  = COM_BASE + 2,
  localparam int CW      = $clog2(NC_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          hold,
  input  logic [1:0]    duty_code,
  output logic [CW-1:0] com_idx,
  output logic          frame_odd,
  output logic [CW-1:0] ncom
);
  logic [CW-1:0] idx_q, idx_d;
  logic          odd_q, odd_d;
  duty_e         duty_q, duty_d;
  logic          adv, last;

  assign ncom = CW'(COM_BASE) + CW'(duty_q);
  assign last = (idx_q == ncom - CW'(1));
  assign adv  = step_en && !hold;

  always_comb begin
    idx_d  = idx_q;
    odd_d  = odd_q;
    duty_d = duty_q;
    if (last) begin
      idx_d  = '0;
      odd_d  = ~odd_q;
      duty_d = decode_duty(duty_code);
    end else begin
      idx_d  = idx_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      odd_q  <= 1'b0;
      duty_q <= DUTY_BASE;
    end else if (adv) begin
      idx_q  <= idx_d;
      odd_q  <= odd_d;
      duty_q <= duty_d;
    end
  end

  assign com_idx   = idx_q;
  assign frame_odd = odd_q;

  assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < ncom);

  assert_scan_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(idx_q) && $stable(odd_q)));

  assert_duty_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q != $past(duty_q)) |-> ($past(adv && last) && idx_q == '0));

  assert_polarity_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_q != $past(odd_q)) |-> ($past(adv && last) && idx_q == '0));
endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
  import lcd_seq_pkg::*;
#(
  parameter int NC_MAX = 10,
  parameter int CW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     com_idx,
  input  logic              frame_odd,
  input  logic [CW-1:0]     ncom,
  input  logic              hold,
  output logic [NC_MAX*3-1:0] lvl
);
  logic [NC_MAX-1:0] top_active;

  for (genvar c = 0; c < NC_MAX; c++) begin : g_com
    lvl_t l;
    always_comb begin
      if (hold)
        l = LVL_BOT;
      else if (com_idx == CW'(c))
        l = frame_odd ? LVL_BOT : LVL_TOP;
      else
        l = frame_odd ? LVL_HI : LVL_LO;
    end
    assign lvl[c*3 +: 3]  = l;
    assign top_active[c]  = (l == LVL_TOP) && (CW'(c) < ncom);
  end

  assert_one_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !frame_odd) |-> ($countones(top_active) == 1));
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
  import lcd_seq_pkg::*;
#(
  parameter int NS     = 75,
  parameter int DOTS   = 730,
  parameter int CW     = 4,
  localparam int PW    = $clog2(DOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DOTS-1:0] disp_data,
  input  logic [CW-1:0]   com_idx,
  input  logic            frame_odd,
  input  logic [CW-1:0]   ncom,
  input  logic            seg_off,
  input  logic            blank_n,
  input  logic            hold,
  output logic [NS*3-1:0] lvl
);
  for (genvar s = 0; s < NS; s++) begin : g_seg
    logic [31:0] pos;
    logic        dot;
    lvl_t        l;
    assign pos = 32'(s) * 32'(ncom) + 32'(com_idx);
    assign dot = (pos < 32'(DOTS)) ? disp_data[pos[PW-1:0]] : 1'b0;
    always_comb begin
      if (hold || !blank_n)
        l = LVL_BOT;
      else if (seg_off || !dot)
        l = LVL_MID;
      else
        l = frame_odd ? LVL_TOP : LVL_BOT;
    end
    assign lvl[s*3 +: 3] = l;
  end

  assert_off_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_off && blank_n && !hold) |-> (lvl == {NS{LVL_MID}}));

  assert_blank_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_n) |-> (lvl == '0));
endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
  import lcd_seq_pkg::*;
#(
  parameter int SEG_DED  = 73,
  parameter int COM_BASE = 8,
  localparam int NC_MAX  = COM_BASE + 2,
  localparam int NSEG    = SEG_DED + 2,
  localparam int DOTS    = SEG_DED * NC_MAX,
  localparam int CW      = $clog2(NC_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_en,
  input  logic [1:0]            duty_sel,
  input  logic                  seg_off,
  input  logic                  power_save,
  input  logic                  blank_n,
  input  logic [DOTS-1:0]       disp_data,
  output logic [COM_BASE*3-1:0] com_lvl,
  output logic [SEG_DED*3-1:0]  seg_lvl,
  output logic [2:0]            dual_a_lvl,
  output logic [2:0]            dual_b_lvl
);
  logic [CW-1:0]       com_idx, ncom;
  logic                frame_odd;
  logic [NC_MAX*3-1:0] com_all;
  logic [NSEG*3-1:0]   seg_all;

  lcd_scan_timer #(.COM_BASE(COM_BASE)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .hold      (power_save),
    .duty_code (duty_sel),
    .com_idx   (com_idx),
    .frame_odd (frame_odd),
    .ncom      (ncom)
  );

  lcd_com_drive #(.NC_MAX(NC_MAX), .CW(CW)) u_com (
    .clk       (clk),
    .rst_n     (rst_n),
    .com_idx   (com_idx),
    .frame_odd (frame_odd),
    .ncom      (ncom),
    .hold      (power_save),
    .lvl       (com_all)
  );

  lcd_seg_drive #(.NS(NSEG), .DOTS(DOTS), .CW(CW)) u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .disp_data (disp_data),
    .com_idx   (com_idx),
    .frame_odd (frame_odd),
    .ncom      (ncom),
    .seg_off   (seg_off),
    .blank_n   (blank_n),
    .hold      (power_save),
    .lvl       (seg_all)
  );

  assign com_lvl = com_all[COM_BASE*3-1:0];
  assign seg_lvl = seg_all[SEG_DED*3-1:0];

  // Shared pins: common role once the duty reaches them, segment role otherwise.
  always_comb begin
    if (ncom > CW'(COM_BASE))
      dual_a_lvl = blank_n ? com_all[COM_BASE*3 +: 3] : LVL_BOT;
    else
      dual_a_lvl = seg_all[(SEG_DED+1)*3 +: 3];
    if (ncom == CW'(NC_MAX))
      dual_b_lvl = blank_n ? com_all[(COM_BASE+1)*3 +: 3] : LVL_BOT;
    else
      dual_b_lvl = seg_all[SEG_DED*3 +: 3];
  end

  assert_save_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    power_save |-> (com_lvl == '0 && seg_lvl == '0 && dual_a_lvl == '0 && dual_b_lvl == '0));

  assert_shared_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_n) |-> (dual_a_lvl == '0 && dual_b_lvl == '0));
endmodule

// File: tb/lcd_mux_sequencer_test.sv
module lcd_mux_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_DED    = 73;
  localparam int COM_BASE   = 8;
  localparam int NSEG       = SEG_DED + 2;
  localparam int DOTS       = SEG_DED * (COM_BASE + 2);

  logic                  clk;
  logic                  rst_n;
  logic                  step_en;
  logic [1:0]            duty_sel;
  logic                  seg_off;
  logic                  power_save;
  logic                  blank_n;
  logic [DOTS-1:0]       disp_data;
  logic [COM_BASE*3-1:0] com_lvl;
  logic [SEG_DED*3-1:0]  seg_lvl;
  logic [2:0]            dual_a_lvl;
  logic [2:0]            dual_b_lvl;

  int tests;
  int fails;
  bit done;
  int m_idx;
  int m_n;
  bit m_odd;

  lcd_mux_sequencer uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .duty_sel(duty_sel),
    .seg_off(seg_off), .power_save(power_save), .blank_n(blank_n),
    .disp_data(disp_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
    .dual_a_lvl(dual_a_lvl), .dual_b_lvl(dual_b_lvl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ncom_of(input logic [1:0] d);
    if (d[1]) return 10;
    if (d[0]) return 9;
    return 8;
  endfunction

  function automatic logic [2:0] com_exp(input int c);
    if (power_save) return 3'd0;
    if (c == m_idx) return m_odd ? 3'd0 : 3'd4;
    return m_odd ? 3'd3 : 3'd1;
  endfunction

  function automatic logic [2:0] seg_exp(input int s);
    int p;
    logic d;
    if (power_save || !blank_n) return 3'd0;
    if (seg_off) return 3'd2;
    p = s * m_n + m_idx;
    d = (p < DOTS) ? disp_data[p] : 1'b0;
    if (!d) return 3'd2;
    return m_odd ? 3'd4 : 3'd0;
  endfunction

  task automatic check(input string tag);
    logic [COM_BASE*3-1:0] e_com;
    logic [SEG_DED*3-1:0]  e_seg;
    logic [2:0]            e_a, e_b;
    for (int c = 0; c < COM_BASE; c++) e_com[c*3 +: 3] = com_exp(c);
    for (int s = 0; s < SEG_DED; s++) e_seg[s*3 +: 3] = seg_exp(s);
    if (power_save || !blank_n) e_a = 3'd0;
    else if (m_n >= 9) e_a = com_exp(8);
    else e_a = seg_exp(SEG_DED + 1);
    if (power_save || !blank_n) e_b = 3'd0;
    else if (m_n == 10) e_b = com_exp(9);
    else e_b = seg_exp(SEG_DED);
    tests++;
    if (com_lvl !== e_com || seg_lvl !== e_seg || dual_a_lvl !== e_a || dual_b_lvl !== e_b) begin
      fails++;
      $display("FAIL %s: com %h/%h seg %h/%h a %0d/%0d b %0d/%0d (actual/expected)",
               tag, com_lvl, e_com, seg_lvl, e_seg, dual_a_lvl, e_a, dual_b_lvl, e_b);
    end
  endtask

  // Called with clk low and inputs already applied.
  task automatic run_cycle(input string tag);
    #1;
    check(tag);
    @(posedge clk);
    if (step_en && !power_save) begin
      if (m_idx == m_n - 1) begin
        m_idx = 0;
        m_odd = ~m_odd;
        m_n   = ncom_of(duty_sel);
      end else begin
        m_idx++;
      end
    end
    @(negedge clk);
  endtask

  task automatic fill_random;
    logic [31:0] r;
    for (int w = 0; w < DOTS; w += 32) begin
      r = $urandom;
      for (int b = 0; b < 32; b++) if (w + b < DOTS) disp_data[w+b] = r[b];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tests = 0; fails = 0; done = 0;
    rst_n = 1'b0; step_en = 1'b0; duty_sel = 2'd0; seg_off = 1'b0;
    power_save = 1'b0; blank_n = 1'b1; disp_data = '0;
    m_idx = 0; m_n = 8; m_odd = 1'b0;
    // R6: only segment 11 / common 3 at 1/8 duty -> bit 82
    disp_data[82] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_cycle("R1 reset state");
    run_cycle("R1 idle without step");

    step_en = 1'b1;
    for (int i = 0; i < 18; i++) run_cycle("R3 R4 R6 scan and dot map");

    disp_data = '1;
    for (int i = 0; i < 16; i++) run_cycle("R5 all dots on");

    fill_random();
    duty_sel = 2'd2;
    for (int i = 0; i < 24; i++) run_cycle("R2 R7 switch to ten commons");
    duty_sel = 2'd1;
    for (int i = 0; i < 30; i++) run_cycle("R2 R7 switch to nine commons");
    duty_sel = 2'd3;
    for (int i = 0; i < 22; i++) run_cycle("R2 code three");
    duty_sel = 2'd0;
    for (int i = 0; i < 20; i++) run_cycle("R7 back to eight");

    seg_off = 1'b1;
    for (int i = 0; i < 12; i++) run_cycle("R8 segments forced off");
    seg_off = 1'b0;

    power_save = 1'b1;
    for (int i = 0; i < 6; i++) run_cycle("R9 power save hold");
    power_save = 1'b0;
    for (int i = 0; i < 4; i++) run_cycle("R9 resume");

    blank_n = 1'b0;
    seg_off = 1'b1;
    for (int i = 0; i < 12; i++) run_cycle("R10 inhibit");
    power_save = 1'b1;
    run_cycle("R10 R9 precedence");
    power_save = 1'b0;
    blank_n = 1'b1;
    seg_off = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0) fill_random();
      step_en    = ($urandom % 4) != 0;
      if ($urandom % 40 == 0) duty_sel = 2'($urandom);
      seg_off    = ($urandom % 10) == 0;
      power_save = ($urandom % 20) == 0;
      blank_n    = ($urandom % 20) != 0;
      run_cycle("R4 R5 R6 R7 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule